// File: doc/BRIEF.md
# Byte-Granular Register Write Guard

This block stands between a bus slave port and the register file of a peripheral that needs protection against stray writes. Every byte of the peripheral's register window can be locked. A locked byte cannot be written again until its lock is cleared. Software sets locks in one of two ways. It can write a register through an alias window, which updates the register and locks the bytes it wrote in the same clock. It can also write the lock-bit registers directly, under a per-bit mask.

The local byte address space is 16 KB and holds four regions. The first is a direct window onto the peripheral registers at 0x0000–0x17FF. The second is an alias window at 0x2000–0x37FF: offset 0x2000+X reaches register byte X. The third is a lock-bit register array starting at 0x3800. The fourth is a global control word at 0x3FFC. The control word holds a sticky freeze bit and a user-access enable. Once the freeze bit is set, no lock bit can change until reset.

Accesses that are allowed go through to the peripheral on a plain register-file port in the same cycle. The bus sees an acknowledge, an error flag and read data one cycle after each request. Only the first `LOCK_WORDS` register words have lock bits. Words above that are always writable.

Top module: `regprot_wrapper`

## Requirements
- R1: A read or write to byte offset X in 0x0000–0x17FF reaches the register file in the same cycle with word index X[12:2], the bus byte enables and the bus data. One cycle after any request, the bus acknowledge is high, and a read without error returns the register-file data.
- R2: An access at 0x2000+X acts on register word X[12:2] exactly as a direct access does. A mirror write that succeeds also sets, at the same clock edge, the lock bit of every byte it enables.
- R3: If a write's byte enables include even one locked byte of the target word, the response is an error and the register-file write strobe stays low, so no byte of that word changes.
- R4: Reads are never refused because of lock bits.
- R5: The lock register at 0x3800+4k covers register words 4k..4k+3. Byte j of that register belongs to word 4k+j. Within byte j, bit b (0–3) is the lock of that word's byte b, and bit 4+b is a write mask. A direct write changes lock b only where its mask bit is 1. Mask bits always read back as 0.
- R6: Bit 0 of the control word at 0x3FFC is the freeze bit. A write of 1 sets it, a write of 0 does not clear it, and only reset clears it. While it is set, no lock bit changes: mirror writes still update the register but set no lock, and direct lock writes have no effect.
- R7: Register words at or above `LOCK_WORDS` have no lock bits. A mirror write to them sets nothing, and any access to a lock register beyond the implemented ones returns an error.
- R8: Accesses to 0x1800–0x1FFF, to unimplemented lock registers up to 0x3DFF, and to 0x3E00–0x3FFB return an error and change nothing.
- R9: Bit 1 of the control word is the user-access enable. While it is 0, a user-mode access to either register window returns an error and does not reach the register file. A user-mode access to the lock array or to the control word always returns an error.
- R10: Reset clears every lock bit, the freeze bit, the user-access enable, the acknowledge and the error flag.
- R11: The control word reads back as freeze in bit 0, user enable in bit 1 and zeros elsewhere. Erroring reads and all writes return read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_rd | input | 1 | Read request strobe |
| bus_wr | input | 1 | Write request strobe |
| bus_user | input | 1 | Request is issued in user mode |
| bus_addr | input | 14 | Local byte address (word aligned) |
| bus_be | input | 4 | Byte enables |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Response valid, one cycle after the request |
| bus_err | output | 1 | Transfer error on the response |
| bus_rdata | output | 32 | Read data on the response |
| rf_rd | output | 1 | Register-file read strobe |
| rf_wr | output | 1 | Register-file write strobe |
| rf_addr | output | 11 | Register word index |
| rf_be | output | 4 | Register-file byte enables |
| rf_wdata | output | 32 | Register-file write data |
| rf_rdata | input | 32 | Register-file read data |

## Verification
The bench goes after partially locked words. A guard that tested only some of the enabled bytes would let a mixed write change the free bytes, which the all-or-nothing rule forbids. It sets locks through the mirror alias and through masked direct writes, and then reads the lock array back. A mask decoded the wrong way, or the wrong nibble-to-word mapping, shows up as a wrong lock pattern or a wrong refusal. After freezing, the bench tries to clear the freeze bit, writes through the mirror, and writes the lock array. A freeze that was not sticky, or that also blocked the register update, gives a result that differs from the model. It also covers user-mode refusals, the reserved holes, words above the lockable range, and a reset in the middle of the test that must drop every lock but no register contents.

// File: rtl/regprot_pkg.sv
package regprot_pkg;

    localparam int WORD_IDX_W = 11;
    localparam int LREG_IDX_W = 9;

    typedef enum logic [2:0] {
        RG_BAD,
        RG_DIRECT,
        RG_MIRROR,
        RG_LOCK,
        RG_CFG
    } region_e;

    typedef struct packed {
        logic hard;
        logic user_en;
    } cfg_t;

    typedef struct packed {
        logic        ack;
        logic        err;
        logic [31:0] rdata;
    } resp_t;

    typedef struct packed {
        cfg_t  cfg;
        resp_t resp;
    } state_t;

endpackage

// File: rtl/regprot_decode.sv
module regprot_decode
    import regprot_pkg::*;
#(
    parameter int LOCK_REGS = 12
) (
    input  logic [13:0]           addr,
    output region_e               region,
    output logic [WORD_IDX_W-1:0] word_idx,
    output logic [LREG_IDX_W-1:0] lreg_idx
);

    logic [1:0] unused_low;
    assign unused_low = addr[1:0];

    always_comb begin
        word_idx = addr[12:2];
        lreg_idx = addr[10:2];
        region   = RG_BAD;
        if (addr[12:11] != 2'b11) begin
            region = addr[13] ? RG_MIRROR : RG_DIRECT;
        end else if (addr[13]) begin
            if (addr[10:9] != 2'b11) begin
                if (int'(addr[10:2]) < LOCK_REGS) begin
                    region = RG_LOCK;
                end
            end else if (addr[10:2] == '1) begin
                region = RG_CFG;
            end
        end
    end

endmodule

// File: rtl/regprot_lockbank.sv
module regprot_lockbank
    import regprot_pkg::*;
#(
    parameter int LOCK_WORDS = 48
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  frozen,
    input  logic                  mset_en,
    input  logic [WORD_IDX_W-1:0] mset_word,
    input  logic [3:0]            mset_be,
    input  logic                  dwr_en,
    input  logic [LREG_IDX_W-1:0] dwr_idx,
    input  logic [3:0]            dwr_be,
    input  logic [31:0]           dwr_data,
    input  logic [WORD_IDX_W-1:0] chk_word,
    output logic [3:0]            chk_nib,
    input  logic [LREG_IDX_W-1:0] rd_idx,
    output logic [31:0]           rd_data
);

    localparam int LOCK_REGS = LOCK_WORDS / 4;

    logic [LOCK_WORDS-1:0][3:0] lock_d, lock_q;

    always_comb begin
        lock_d = lock_q;
        if (!frozen) begin
            for (int w = 0; w < LOCK_WORDS; w++) begin
                if (mset_en && mset_word == WORD_IDX_W'(w)) begin
                    lock_d[w] = lock_q[w] | mset_be;
                end
                if (dwr_en && dwr_idx == LREG_IDX_W'(w / 4) && dwr_be[w % 4]) begin
                    for (int b = 0; b < 4; b++) begin
                        if (dwr_data[8 * (w % 4) + 4 + b]) begin
                            lock_d[w][b] = dwr_data[8 * (w % 4) + b];
                        end
                    end
                end
            end
        end
    end

    always_comb begin
        chk_nib = 4'h0;
        for (int w = 0; w < LOCK_WORDS; w++) begin
            if (chk_word == WORD_IDX_W'(w)) begin
                chk_nib = lock_q[w];
            end
        end
    end

    always_comb begin
        rd_data = 32'h0;
        for (int k = 0; k < LOCK_REGS; k++) begin
            if (rd_idx == LREG_IDX_W'(k)) begin
                for (int j = 0; j < 4; j++) begin
                    rd_data[8 * j +: 4] = lock_q[4 * k + j];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            lock_q <= '0;
        end else begin
            lock_q <= lock_d;
        end
    end

    assert_frozen_locks_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(lock_q));

    assert_mirror_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mset_en && !frozen && int'(mset_word) < LOCK_WORDS && mset_be != 4'h0)
        |=> chk_nib != 4'h0 || chk_word != $past(mset_word));

endmodule

// File: rtl/regprot_wrapper.sv
module regprot_wrapper
    import regprot_pkg::*;
#(
    parameter int LOCK_WORDS = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_rd,
    input  logic        bus_wr,
    input  logic        bus_user,
    input  logic [13:0] bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic        bus_ack,
    output logic        bus_err,
    output logic [31:0] bus_rdata,
    output logic        rf_rd,
    output logic        rf_wr,
    output logic [10:0] rf_addr,
    output logic [3:0]  rf_be,
    output logic [31:0] rf_wdata,
    input  logic [31:0] rf_rdata
);

    localparam int LOCK_REGS = LOCK_WORDS / 4;

    region_e               region;
    logic [WORD_IDX_W-1:0] word_idx;
    logic [LREG_IDX_W-1:0] lreg_idx;
    logic [3:0]            lk_nib;
    logic [31:0]           lk_rdata;
    logic                  req, in_regs, deny;
    logic                  mset_en, dwr_en;
    state_t                st_d, st_q;

    regprot_decode #(.LOCK_REGS(LOCK_REGS)) u_decode (
        .addr     (bus_addr),
        .region   (region),
        .word_idx (word_idx),
        .lreg_idx (lreg_idx)
    );

    regprot_lockbank #(.LOCK_WORDS(LOCK_WORDS)) u_locks (
        .clk       (clk),
        .rst_n     (rst_n),
        .frozen    (st_q.cfg.hard),
        .mset_en   (mset_en),
        .mset_word (word_idx),
        .mset_be   (bus_be),
        .dwr_en    (dwr_en),
        .dwr_idx   (lreg_idx),
        .dwr_be    (bus_be),
        .dwr_data  (bus_wdata),
        .chk_word  (word_idx),
        .chk_nib   (lk_nib),
        .rd_idx    (lreg_idx),
        .rd_data   (lk_rdata)
    );

    always_comb begin
        req     = bus_rd | bus_wr;
        in_regs = (region == RG_DIRECT) || (region == RG_MIRROR);
        deny    = 1'b0;
        if (region == RG_BAD) deny = 1'b1;
        if (bus_user && (!in_regs || !st_q.cfg.user_en)) deny = 1'b1;
        if (bus_wr && in_regs && ((lk_nib & bus_be) != 4'h0)) deny = 1'b1;
    end

    assign rf_wr    = bus_wr && in_regs && !deny;
    assign rf_rd    = bus_rd && !bus_wr && in_regs && !deny;
    assign rf_addr  = word_idx;
    assign rf_be    = bus_be;
    assign rf_wdata = bus_wdata;
    assign mset_en  = rf_wr && (region == RG_MIRROR);
    assign dwr_en   = bus_wr && (region == RG_LOCK) && !deny;

    always_comb begin
        st_d            = st_q;
        st_d.resp.ack   = req;
        st_d.resp.err   = req && deny;
        st_d.resp.rdata = 32'h0;
        if (bus_rd && !bus_wr && !deny) begin
            unique case (region)
                RG_DIRECT, RG_MIRROR: st_d.resp.rdata = rf_rdata;
                RG_LOCK:              st_d.resp.rdata = lk_rdata;
                RG_CFG:               st_d.resp.rdata = {30'h0, st_q.cfg.user_en, st_q.cfg.hard};
                default:              st_d.resp.rdata = 32'h0;
            endcase
        end
        if (bus_wr && region == RG_CFG && !deny && bus_be[0]) begin
            st_d.cfg.hard    = st_q.cfg.hard | bus_wdata[0];
            st_d.cfg.user_en = bus_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_ack   = st_q.resp.ack;
    assign bus_err   = st_q.resp.err;
    assign bus_rdata = st_q.resp.rdata;

    assert_ack_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd || bus_wr) |=> bus_ack);

    assert_no_locked_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr |-> ((lk_nib & rf_be) == 4'h0));

    assert_hard_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cfg.hard |=> st_q.cfg.hard);

    assert_reserved_err_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_rd || bus_wr) && bus_addr[13:11] == 3'b011) |=> bus_err);

    assert_user_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_user && !st_q.cfg.user_en) |-> !(rf_wr || rf_rd));

    assert_strobes_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rf_rd, rf_wr}));

endmodule

// File: tb/regprot_wrapper_test.sv
module regprot_wrapper_test;

    localparam int LOCK_WORDS = 48;
    localparam int MEM_WORDS  = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_user = 1'b0;
    logic [13:0] bus_addr = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, bus_err;
    logic [31:0] bus_rdata;
    logic        rf_rd, rf_wr;
    logic [10:0] rf_addr;
    logic [3:0]  rf_be;
    logic [31:0] rf_wdata, rf_rdata;

    always #2.5 clk = ~clk;

    regprot_wrapper #(.LOCK_WORDS(LOCK_WORDS)) uut (
        .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_user(bus_user),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_ack(bus_ack), .bus_err(bus_err), .bus_rdata(bus_rdata),
        .rf_rd(rf_rd), .rf_wr(rf_wr), .rf_addr(rf_addr), .rf_be(rf_be),
        .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
    );

    // protected peripheral stand-in
    logic [31:0] pmem [MEM_WORDS];
    assign rf_rdata = (int'(rf_addr) < MEM_WORDS) ? pmem[rf_addr[5:0]] : 32'h0;
    always @(posedge clk) begin
        if (rf_wr && int'(rf_addr) < MEM_WORDS) begin
            for (int i = 0; i < 4; i++)
                if (rf_be[i]) pmem[rf_addr[5:0]][8*i +: 8] <= rf_wdata[8*i +: 8];
        end
    end

    // reference model
    logic [31:0] mmem [MEM_WORDS];
    bit          mlock [LOCK_WORDS*4];
    bit          mhard, muser;
    bit          exp_ack, exp_err;
    logic [31:0] exp_rdata;
    string       exp_tag = "R10";
    int          checks = 0, fails = 0;

    task automatic model_req(input bit rd, input bit wr, input bit user, input int a,
                             input logic [3:0] be, input logic [31:0] wd);
        int  kind, word, k;
        bit  locked;
        exp_ack = rd | wr; exp_err = 0; exp_rdata = 0;
        if (!(rd | wr)) return;
        if (a < 'h1800) kind = 1;
        else if (a < 'h2000) kind = 0;
        else if (a < 'h3800) kind = 2;
        else if (a < 'h3E00) kind = (((a - 'h3800) / 4) < LOCK_WORDS / 4) ? 3 : 0;
        else if (a >= 'h3FFC) kind = 4;
        else kind = 0;
        word = (a % 'h2000) / 4;
        k = (a - 'h3800) / 4;
        if (kind == 0) exp_err = 1;
        if (user && (kind > 2 || !muser)) exp_err = 1;
        locked = 0;
        if (wr && (kind == 1 || kind == 2) && word < LOCK_WORDS)
            for (int i = 0; i < 4; i++) if (be[i] && mlock[word*4+i]) locked = 1;
        if (locked) exp_err = 1;
        if (exp_err) return;
        if (wr) begin
            if (kind == 1 || kind == 2) begin
                for (int i = 0; i < 4; i++) if (be[i] && word < MEM_WORDS) mmem[word][8*i +: 8] = wd[8*i +: 8];
                if (kind == 2 && word < LOCK_WORDS && !mhard)
                    for (int i = 0; i < 4; i++) if (be[i]) mlock[word*4+i] = 1;
            end else if (kind == 3) begin
                if (!mhard)
                    for (int j = 0; j < 4; j++)
                        if (be[j])
                            for (int b = 0; b < 4; b++)
                                if (wd[8*j+4+b]) mlock[(4*k+j)*4+b] = wd[8*j+b];
            end else if (be[0]) begin
                mhard = mhard | wd[0];
                muser = wd[1];
            end
        end else begin
            if (kind == 1 || kind == 2) exp_rdata = (word < MEM_WORDS) ? mmem[word] : 32'h0;
            else if (kind == 3) begin
                for (int j = 0; j < 4; j++)
                    for (int b = 0; b < 4; b++) exp_rdata[8*j+b] = mlock[(4*k+j)*4+b];
            end else exp_rdata = {30'h0, muser, mhard};
        end
    endtask

    // one clock: compare last response, then issue the next request
    task automatic cyc(input bit rd, input bit wr, input bit user, input int a,
                       input logic [3:0] be, input logic [31:0] wd, input string tag);
        bit mem_ok;
        @(negedge clk);
        checks++;
        if (bus_ack !== exp_ack || bus_err !== exp_err || bus_rdata !== exp_rdata) begin
            fails++;
            $display("FAIL %s: ack/err/rdata = %b/%b/%h, expected %b/%b/%h",
                     exp_tag, bus_ack, bus_err, bus_rdata, exp_ack, exp_err, exp_rdata);
        end
        mem_ok = 1;
        for (int i = 0; i < MEM_WORDS; i++) if (pmem[i] !== mmem[i]) mem_ok = 0;
        checks++;
        if (!mem_ok) begin
            fails++;
            $display("FAIL %s: register file differs, word3=%h expected %h", exp_tag, pmem[3], mmem[3]);
        end
        model_req(rd, wr, user, a, be, wd);
        exp_tag   = tag;
        bus_rd    = rd; bus_wr = wr; bus_user = user;
        bus_addr  = 14'(a); bus_be = be; bus_wdata = wd;
    endtask

    task automatic rd(input int a, input string tag);
        cyc(1, 0, 0, a, 4'hF, 32'h0, tag);
    endtask
    task automatic wr(input int a, input logic [3:0] be, input logic [31:0] d, input string tag);
        cyc(0, 1, 0, a, be, d, tag);
    endtask
    task automatic idle(input string tag);
        cyc(0, 0, 0, 0, 4'h0, 32'h0, tag);
    endtask

    task automatic do_reset();
        idle("R10");
        @(negedge clk);
        rst_n = 0;
        mhard = 0; muser = 0;
        for (int i = 0; i < LOCK_WORDS*4; i++) mlock[i] = 0;
        exp_ack = 0; exp_err = 0; exp_rdata = 0; exp_tag = "R10";
        repeat (2) @(negedge clk);
        rst_n = 1;
    endtask

    initial begin
        #200000;
        fails++;
        $display("FAIL watchdog: run did not finish, got hang expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < MEM_WORDS; i++) begin pmem[i] = 0; mmem[i] = 0; end
        mhard = 0; muser = 0;
        for (int i = 0; i < LOCK_WORDS*4; i++) mlock[i] = 0;
        exp_ack = 0; exp_err = 0; exp_rdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        idle("R10");
        rd('h3FFC, "R10");                          // control word clear after reset
        rd('h3800, "R10");                          // locks clear after reset
        wr('h000C, 4'hF, 32'h11223344, "R1");
        rd('h000C, "R1");
        wr('h0010, 4'h5, 32'hAABBCCDD, "R1");
        rd('h0010, "R1");
        wr('h2014, 4'h3, 32'hCAFE0102, "R2");      // mirror write locks bytes 0,1 of word 5
        rd('h3804, "R5");                           // byte1 of lock reg 1 should show 3
        wr('h0014, 4'h4, 32'h00770000, "R3");      // free byte only: accepted
        wr('h0014, 4'h6, 32'h00EEFF00, "R3");      // touches byte1: refused whole
        rd('h0014, "R4");
        rd('h2014, "R2");
        wr('h2014, 4'h1, 32'h000000FF, "R3");      // mirror write to locked byte refused
        wr('h3804, 4'h1, 32'h000000F5, "R5");      // word4 locks = 0101
        wr('h3804, 4'h1, 32'h00000022, "R5");      // mask bit1 only: locks = 0111
        wr('h3804, 4'h1, 32'h00000008, "R5");      // no mask bits: no change
        rd('h3804, "R5");
        wr('h0010, 4'h8, 32'h99000000, "R3");      // byte3 free
        wr('h0010, 4'h1, 32'h00000011, "R3");      // byte0 locked
        wr('h0010, 4'h9, 32'h88000022, "R3");      // mixed
        rd('h0010, "R4");
        wr('h20C8, 4'hF, 32'h5A5A5A5A, "R7");      // word 50, no lock bits
        wr('h00C8, 4'hF, 32'hA5A5A5A5, "R7");
        rd('h00C8, "R7");
        wr('h3830, 4'hF, 32'hFFFFFFFF, "R7");      // lock reg 12 not implemented
        rd('h3DFC, "R8");
        wr('h1800, 4'hF, 32'h12345678, "R8");
        rd('h1FFC, "R8");
        rd('h3E00, "R8");
        wr('h3FF8, 4'hF, 32'h3, "R8");
        rd('h3FFC, "R11");
        cyc(1, 0, 1, 'h000C, 4'hF, 32'h0, "R9");   // user, enable clear
        cyc(0, 1, 1, 'h000C, 4'hF, 32'h0, "R9");
        cyc(0, 1, 1, 'h3FFC, 4'h1, 32'h2, "R9");   // user to control word
        wr('h3FFC, 4'h1, 32'h2, "R9");
        rd('h3FFC, "R11");
        cyc(1, 0, 1, 'h000C, 4'hF, 32'h0, "R9");
        cyc(0, 1, 1, 'h2018, 4'h2, 32'h00003300, "R9");
        cyc(1, 0, 1, 'h3804, 4'hF, 32'h0, "R9");   // lock array always refused in user mode
        rd('h3808, "R9");
        wr('h3FFC, 4'h1, 32'h3, "R6");             // freeze
        rd('h3FFC, "R6");
        wr('h2028, 4'hF, 32'h0BADF00D, "R6");      // word 10: written, not locked
        rd('h3808, "R6");
        wr('h3808, 4'hF, 32'hFFFFFFFF, "R6");      // direct lock write ignored
        rd('h3808, "R6");
        wr('h3804, 4'h2, 32'h0000F000, "R6");      // try unlocking word5: ignored
        wr('h0014, 4'h1, 32'h00000001, "R6");
        wr('h3FFC, 4'h1, 32'h0, "R6");             // cannot clear freeze
        rd('h3FFC, "R6");
        rd('h0028, "R6");
        do_reset();
        rd('h3FFC, "R10");
        rd('h3804, "R10");
        wr('h0014, 4'h3, 32'h00004444, "R10");     // old locks gone
        rd('h0014, "R10");
        idle("R1");
        idle("R1");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule